// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Shifter

This block moves a single "row select" bit across the gate-line outputs of a display panel. Each rising edge of the shift clock advances it by one position. A start pulse enters at one end of the chain, and the `shift_right` input sets which end that is. When the pulse leaves the far end, the block raises a carry pulse on the opposite start port, so that a second device in a cascade can take it as its own start pulse. The carry pulse changes on falling clock edges, which gives the next device half a cycle of setup before its own sampling edge.

A full-count input selects between all `NUM_OUT` stages and a shortened chain. The shortened chain jumps over a fixed group of `SKIP_N` middle stages, starting at stage `SKIP_LO`. Two output controls act on the output path only and never on the register contents:
- a blanking input, which drives every output low;
- an active-low force-on input, which drives every valid output high and takes priority over blanking.

Each start port is split into an input, an output and a drive enable, so a pad ring can build the bidirectional pin. Outputs are logic levels; level shifting happens outside the block. In the system, `full_mode` and `force_on_n` are tied high when they are not used.

Top module: `gate_scan_shifter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stage is cleared. A falling edge with `rst_n` low clears the carry. After reset, all of `gate_o` and both pulse outputs are 0.
- R2: With `shift_right`=1 and `full_mode`=1, `right_pulse_i` is sampled on a rising edge. A pulse sampled on clock 1 appears on `gate_o[k]` alone after clock k, for k = 1..NUM_OUT.
- R3: With `shift_right`=0 and `full_mode`=1, `left_pulse_i` is sampled instead. After clock k, the pulse sits on `gate_o[NUM_OUT+1-k]` alone.
- R4: The carry leaves on the port opposite the entry port: `left_pulse_o` when `shift_right`=1, `right_pulse_o` when it is 0. It rises at the falling edge of the clock on which the pulse reached the last stage. It falls at the falling edge of the next clock. In full mode, that is the falling edge of clock NUM_OUT and then of clock NUM_OUT+1.
- R5: With `full_mode`=0, the chain has NUM_OUT−SKIP_N stages. Outputs SKIP_LO..SKIP_LO+SKIP_N−1 stay 0, even under force-on. The pulse moves directly between stages SKIP_LO−1 and SKIP_LO+SKIP_N, and the carry rises at the falling edge of clock NUM_OUT−SKIP_N.
- R6: While `blank`=1 and `force_on_n`=1, all of `gate_o` is 0 without waiting for a clock. The pulse keeps shifting, and it reappears at its advanced position once `blank` returns to 0.
- R7: While `force_on_n`=0, every valid output is 1 without waiting for a clock, whatever the value of `blank`. Register contents are kept.
- R8: `gate_o[0]` and `gate_o[NUM_OUT+1]` are always 0.
- R9: When `shift_right`=1, `left_pulse_oe`=1 and `right_pulse_oe`=0. When `shift_right`=0, the enables are the other way round. A pulse output is 0 whenever its enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_right | input | 1 | 1: pulse travels from output 1 upward; 0: from output NUM_OUT downward |
| full_mode | input | 1 | 1: all stages used; 0: middle group bypassed |
| blank | input | 1 | 1: all outputs forced low |
| force_on_n | input | 1 | 0: all valid outputs forced high, overrides blank |
| right_pulse_i | input | 1 | Start pulse input at the right port |
| right_pulse_o | output | 1 | Carry output at the right port |
| right_pulse_oe | output | 1 | Drive enable of the right port |
| left_pulse_i | input | 1 | Start pulse input at the left port |
| left_pulse_o | output | 1 | Carry output at the left port |
| left_pulse_oe | output | 1 | Drive enable of the left port |
| gate_o | output | NUM_OUT+2 | Gate-line outputs 0..NUM_OUT+1, end bits tied low |

## Verification
The bench builds the block with NUM_OUT=23, SKIP_LO=9 and SKIP_N=3. At that size a complete pass of the pulse takes 23 clocks in full mode and 20 in short mode. Carry timing can therefore be checked in both directions and both modes, each within a few dozen cycles. The small size also leaves room for thousands of random cycles, in which direction flips, mode flips and overlapping pulses reach the bypass joints at stages 8 and 12.

// File: rtl/gsr_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the gate scan shifter.
// Assumes stage numbers start at 1 and that the skipped group lies strictly
// inside the chain.
package gsr_pkg;

    // True when stage k lies in the group that the short mode bypasses.
    function automatic bit in_skip(input int k, input int lo, input int n);
        return (k >= lo) && (k < lo + n);
    endfunction

endpackage

// File: rtl/gsr_port_mux.sv
`timescale 1ns/1ps
// Module: gsr_port_mux
// Picks the start input and routes the carry to the outgoing port according to
// the direction. Assumes the pad ring builds the bidirectional pin from the
// o/oe pair.
module gsr_port_mux (
    input  logic shift_right,
    input  logic carry_i,
    input  logic right_pulse_i,
    input  logic left_pulse_i,
    output logic start_o,
    output logic right_pulse_o,
    output logic right_pulse_oe,
    output logic left_pulse_o,
    output logic left_pulse_oe
);

    // Entry port follows direction, exit port is the opposite one.
    always_comb begin
        start_o        = shift_right ? right_pulse_i : left_pulse_i;
        left_pulse_oe  = shift_right;
        right_pulse_oe = !shift_right;
        left_pulse_o   = shift_right & carry_i;
        right_pulse_o  = !shift_right & carry_i;
    end

endmodule

// File: rtl/gsr_chain.sv
`timescale 1ns/1ps
// Module: gsr_chain
// Direction-reversible register chain of NUM_OUT stages. In short mode the
// SKIP_N stages from SKIP_LO are held clear and bypassed. Assumes
// SKIP_LO >= 2, SKIP_N >= 1 and SKIP_LO+SKIP_N <= NUM_OUT.
module gsr_chain #(
    parameter int NUM_OUT = 263,
    parameter int SKIP_LO = 129,
    parameter int SKIP_N  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_right,
    input  logic               full_mode,
    input  logic               start_i,
    output logic [NUM_OUT:1]   stage_q,
    output logic               last_o
);

    localparam int SKIP_HI = SKIP_LO + SKIP_N - 1;

    logic [NUM_OUT:1] stage_d;

    for (genvar k = 1; k <= NUM_OUT; k++) begin : g_stage
        logic from_lower;
        logic from_upper;

        // Neighbour feeding this stage when shifting toward higher numbers.
        if (k == 1) begin : g_lo_entry
            assign from_lower = start_i;
        end else if (k == SKIP_HI + 1) begin : g_lo_join
            assign from_lower = full_mode ? stage_q[k-1] : stage_q[SKIP_LO-1];
        end else begin : g_lo_plain
            assign from_lower = stage_q[k-1];
        end

        // Neighbour feeding this stage when shifting toward lower numbers.
        if (k == NUM_OUT) begin : g_up_entry
            assign from_upper = start_i;
        end else if (k == SKIP_LO - 1) begin : g_up_join
            assign from_upper = full_mode ? stage_q[k+1] : stage_q[SKIP_HI+1];
        end else begin : g_up_plain
            assign from_upper = stage_q[k+1];
        end

        // Skipped stages load zero in short mode.
        if (gsr_pkg::in_skip(k, SKIP_LO, SKIP_N)) begin : g_skippable
            assign stage_d[k] = full_mode & (shift_right ? from_lower : from_upper);
        end else begin : g_always
            assign stage_d[k] = shift_right ? from_lower : from_upper;
        end
    end

    // Advance the chain on the rising shift clock edge.
    always_ff @(posedge clk) begin : p_shift
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    // Last stage in the current direction feeds the carry.
    assign last_o = shift_right ? stage_q[NUM_OUT] : stage_q[1];

endmodule

// File: rtl/gsr_carry.sv
`timescale 1ns/1ps
// Module: gsr_carry
// Retimes the last-stage bit on the falling edge, so the carry rises half a
// cycle after the pulse reaches the end. Assumes clk is the shift clock.
module gsr_carry (
    input  logic clk,
    input  logic rst_n,
    input  logic last_i,
    output logic carry_q
);

    // Capture the end-of-chain bit on the falling edge.
    always_ff @(negedge clk) begin : p_carry
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else begin
            carry_q <= last_i;
        end
    end

endmodule

// File: rtl/gsr_out_ctrl.sv
`timescale 1ns/1ps
// Module: gsr_out_ctrl
// Combinational output stage: force-on beats blank, which beats the register
// bit. End outputs are tied low and skipped outputs are low in short mode.
// Assumes the register bits are held elsewhere and are not touched here.
module gsr_out_ctrl #(
    parameter int NUM_OUT = 263,
    parameter int SKIP_LO = 129,
    parameter int SKIP_N  = 7
) (
    input  logic               full_mode,
    input  logic               blank,
    input  logic               force_on_n,
    input  logic [NUM_OUT:1]   stage_q,
    output logic [NUM_OUT+1:0] gate_o
);

    localparam int TOP = NUM_OUT + 1;

    for (genvar k = 0; k <= TOP; k++) begin : g_out
        // Each output resolves its own override chain.
        if (k == 0 || k == TOP) begin : g_edge
            assign gate_o[k] = 1'b0;
        end else if (gsr_pkg::in_skip(k, SKIP_LO, SKIP_N)) begin : g_skip
            assign gate_o[k] = full_mode & (!force_on_n | (!blank & stage_q[k]));
        end else begin : g_norm
            assign gate_o[k] = !force_on_n | (!blank & stage_q[k]);
        end
    end

endmodule

// File: rtl/gate_scan_shifter.sv
`timescale 1ns/1ps
// Module: gate_scan_shifter
// Top of the gate-line scan shifter: port routing, register chain, carry
// retiming and output overrides. Assumes one shift clock and a synchronous
// active-low reset.
module gate_scan_shifter #(
    parameter int NUM_OUT = 263,
    parameter int SKIP_LO = 129,
    parameter int SKIP_N  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_right,
    input  logic               full_mode,
    input  logic               blank,
    input  logic               force_on_n,
    input  logic               right_pulse_i,
    output logic               right_pulse_o,
    output logic               right_pulse_oe,
    input  logic               left_pulse_i,
    output logic               left_pulse_o,
    output logic               left_pulse_oe,
    output logic [NUM_OUT+1:0] gate_o
);

    logic               start_w;
    logic               last_w;
    logic               carry_w;
    logic [NUM_OUT:1]   stage_w;

    gsr_port_mux u_ports (
        .shift_right    (shift_right),
        .carry_i        (carry_w),
        .right_pulse_i  (right_pulse_i),
        .left_pulse_i   (left_pulse_i),
        .start_o        (start_w),
        .right_pulse_o  (right_pulse_o),
        .right_pulse_oe (right_pulse_oe),
        .left_pulse_o   (left_pulse_o),
        .left_pulse_oe  (left_pulse_oe)
    );

    gsr_chain #(.NUM_OUT(NUM_OUT), .SKIP_LO(SKIP_LO), .SKIP_N(SKIP_N)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_right (shift_right),
        .full_mode   (full_mode),
        .start_i     (start_w),
        .stage_q     (stage_w),
        .last_o      (last_w)
    );

    gsr_carry u_carry (
        .clk     (clk),
        .rst_n   (rst_n),
        .last_i  (last_w),
        .carry_q (carry_w)
    );

    gsr_out_ctrl #(.NUM_OUT(NUM_OUT), .SKIP_LO(SKIP_LO), .SKIP_N(SKIP_N)) u_out (
        .full_mode  (full_mode),
        .blank      (blank),
        .force_on_n (force_on_n),
        .stage_q    (stage_w),
        .gate_o     (gate_o)
    );

endmodule

// File: rtl/gsr_checker.sv
`timescale 1ns/1ps
// Module: gsr_checker
// Port-level properties of gate_scan_shifter, attached with bind.
module gsr_checker #(
    parameter int NUM_OUT = 263,
    parameter int SKIP_LO = 129,
    parameter int SKIP_N  = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               shift_right,
    input logic               full_mode,
    input logic               blank,
    input logic               force_on_n,
    input logic               right_pulse_o,
    input logic               right_pulse_oe,
    input logic               left_pulse_o,
    input logic               left_pulse_oe,
    input logic [NUM_OUT+1:0] gate_o
);

    p_edge_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o[0] == 1'b0) && (gate_o[NUM_OUT+1] == 1'b0));

    p_port_roles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({right_pulse_oe, left_pulse_oe}) && (left_pulse_oe == shift_right));

    p_idle_port_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!right_pulse_oe |-> !right_pulse_o) and (!left_pulse_oe |-> !left_pulse_o));

    p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_on_n && blank) |-> (gate_o == '0));

    p_force_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !force_on_n |-> (gate_o[1] && gate_o[NUM_OUT] && gate_o[SKIP_LO-1]));

    p_skip_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !full_mode |-> (gate_o[SKIP_LO +: SKIP_N] == '0));

    p_carry_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (force_on_n && !blank && shift_right && $stable(shift_right))
            |-> (left_pulse_o == gate_o[NUM_OUT]));

endmodule

bind gate_scan_shifter gsr_checker #(
    .NUM_OUT(NUM_OUT), .SKIP_LO(SKIP_LO), .SKIP_N(SKIP_N)
) u_gsr_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .shift_right    (shift_right),
    .full_mode      (full_mode),
    .blank          (blank),
    .force_on_n     (force_on_n),
    .right_pulse_o  (right_pulse_o),
    .right_pulse_oe (right_pulse_oe),
    .left_pulse_o   (left_pulse_o),
    .left_pulse_oe  (left_pulse_oe),
    .gate_o         (gate_o)
);

// File: tb/gate_scan_shifter_test.sv
`timescale 1ns/1ps
module gate_scan_shifter_test;

    localparam int N  = 23;
    localparam int SL = 9;
    localparam int SN = 3;
    localparam int SH = SL + SN - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_right = 1'b1;
    logic         full_mode = 1'b1;
    logic         blank = 1'b0;
    logic         force_on_n = 1'b1;
    logic         right_pulse_i = 1'b0;
    logic         left_pulse_i = 1'b0;
    logic         right_pulse_o, right_pulse_oe, left_pulse_o, left_pulse_oe;
    logic [N+1:0] gate_o;

    int checks = 0;
    int fails  = 0;

    logic [N:1] m = '0;
    logic       carry_m = 1'b0;

    always #10 clk = ~clk;

    gate_scan_shifter #(.NUM_OUT(N), .SKIP_LO(SL), .SKIP_N(SN)) uut (
        .clk(clk), .rst_n(rst_n), .shift_right(shift_right), .full_mode(full_mode),
        .blank(blank), .force_on_n(force_on_n),
        .right_pulse_i(right_pulse_i), .right_pulse_o(right_pulse_o),
        .right_pulse_oe(right_pulse_oe),
        .left_pulse_i(left_pulse_i), .left_pulse_o(left_pulse_o),
        .left_pulse_oe(left_pulse_oe),
        .gate_o(gate_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit skipped(input int k, input bit full);
        return !full && k >= SL && k <= SH;
    endfunction

    // Reference next state built from the shifting rules.
    function automatic logic [N:1] model_next(input logic [N:1] mm, input bit st,
                                              input bit dir, input bit full);
        logic [N:1] n;
        for (int k = 1; k <= N; k++) begin
            if (skipped(k, full)) n[k] = 1'b0;
            else if (dir) n[k] = (k == 1) ? st : (!full && k == SH + 1) ? mm[SL-1] : mm[k-1];
            else n[k] = (k == N) ? st : (!full && k == SL - 1) ? mm[SH+1] : mm[k+1];
        end
        return n;
    endfunction

    function automatic logic [63:0] exp_gate(input logic [N:1] mm, input bit full,
                                             input bit blk, input bit fon_n);
        logic [63:0] r = '0;
        for (int k = 1; k <= N; k++)
            r[k] = skipped(k, full) ? 1'b0 : (!fon_n ? 1'b1 : (!blk && mm[k]));
        return r;
    endfunction

    // Stage holding a single pulse after clock k.
    function automatic int exp_pos(input int k, input bit dir, input bit full);
        int cnt = full ? N : N - SN;
        if (k < 1 || k > cnt) return 0;
        if (dir) return (full || k <= SL - 1) ? k : k + SN;
        return (full || k <= N - SH) ? N + 1 - k : N + 1 - k - SN;
    endfunction

    function automatic logic [63:0] onehot(input int p);
        return (p == 0) ? 64'd0 : (64'd1 << p);
    endfunction

    // One clock: model update and gate check after the rising edge, carry and
    // port check after the falling edge; returns at falling edge + 2 ns.
    task automatic cycle();
        @(posedge clk);
        if (!rst_n) m = '0;
        else m = model_next(m, shift_right ? right_pulse_i : left_pulse_i,
                            shift_right, full_mode);
        #5;
        chk(gate_o == exp_gate(m, full_mode, blank, force_on_n)[N+1:0],
            "R2 R3 R5 R6 R7 R8 gate", 64'(gate_o), exp_gate(m, full_mode, blank, force_on_n));
        @(negedge clk);
        carry_m = rst_n ? (shift_right ? m[N] : m[1]) : 1'b0;
        #2;
        chk({right_pulse_o, right_pulse_oe, left_pulse_o, left_pulse_oe} ==
            {!shift_right & carry_m, !shift_right, shift_right & carry_m, shift_right},
            "R4 R9 ports",
            64'({right_pulse_o, right_pulse_oe, left_pulse_o, left_pulse_oe}),
            64'({!shift_right & carry_m, !shift_right, shift_right & carry_m, shift_right}));
    endtask

    task automatic run_pulse(input bit dir, input bit full);
        int cnt = full ? N : N - SN;
        shift_right = dir;
        full_mode = full;
        repeat (N + 2) cycle();
        if (dir) right_pulse_i = 1'b1; else left_pulse_i = 1'b1;
        cycle();
        right_pulse_i = 1'b0;
        left_pulse_i = 1'b0;
        for (int k = 1; k <= cnt + 2; k++) begin
            if (k > 1) cycle();
            chk(gate_o == onehot(exp_pos(k, dir, full))[N+1:0],
                full ? (dir ? "R2 walk" : "R3 walk") : "R5 walk",
                64'(gate_o), onehot(exp_pos(k, dir, full)));
            chk((dir ? left_pulse_o : right_pulse_o) == (k == cnt),
                full ? "R4 carry" : "R5 carry",
                64'(dir ? left_pulse_o : right_pulse_o), 64'(k == cnt));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        // R1: reset with start pulses present.
        right_pulse_i = 1'b1;
        left_pulse_i = 1'b1;
        repeat (3) cycle();
        right_pulse_i = 1'b0;
        left_pulse_i = 1'b0;
        chk(gate_o == '0 && !right_pulse_o && !left_pulse_o, "R1 reset",
            64'(gate_o), 64'd0);
        rst_n = 1'b1;
        cycle();

        run_pulse(1'b1, 1'b1);
        run_pulse(1'b0, 1'b1);
        run_pulse(1'b1, 1'b0);
        run_pulse(1'b0, 1'b0);

        // R6 and R7: overrides keep the register contents.
        shift_right = 1'b1;
        full_mode = 1'b1;
        right_pulse_i = 1'b1;
        cycle();
        right_pulse_i = 1'b0;
        repeat (3) cycle();
        blank = 1'b1;
        #1 chk(gate_o == '0, "R6 blank now", 64'(gate_o), 64'd0);
        repeat (2) cycle();
        blank = 1'b0;
        #1 chk(gate_o == onehot(6)[N+1:0], "R6 kept", 64'(gate_o), onehot(6));
        blank = 1'b1;
        force_on_n = 1'b0;
        #1 chk(gate_o == exp_gate('0, 1'b1, 1'b1, 1'b0)[N+1:0], "R7 R8 force on",
               64'(gate_o), exp_gate('0, 1'b1, 1'b1, 1'b0));
        full_mode = 1'b0;
        #1 chk(gate_o == exp_gate('0, 1'b0, 1'b1, 1'b0)[N+1:0], "R5 R7 short force",
               64'(gate_o), exp_gate('0, 1'b0, 1'b1, 1'b0));
        full_mode = 1'b1;
        force_on_n = 1'b1;
        blank = 1'b0;
        #1 chk(gate_o == onehot(6)[N+1:0], "R7 kept", 64'(gate_o), onehot(6));

        // Random phase checked against the model.
        for (int i = 0; i < 3000; i++) begin
            right_pulse_i = ($urandom % 8) == 0;
            left_pulse_i  = ($urandom % 8) == 0;
            blank         = ($urandom % 10) == 0;
            force_on_n    = ($urandom % 16) != 0;
            if (($urandom % 200) == 0) shift_right = !shift_right;
            if (($urandom % 150) == 0) full_mode = !full_mode;
            cycle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule